// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Locked Instruction Set

This block is the test access port of a chip: the sixteen-state controller driven by the test clock and mode select, a 10-bit instruction register, and the data registers that can sit between the serial input and the serial output. These are a 1-bit bypass stage, a 32-bit identification word and a 32-bit user word. When the boundary instructions are active, the serial path runs through an external boundary chain. The block drives that chain's capture, shift and update strobes and returns the chain's serial output on its own serial output.

The instruction decoder can run in a locked mode. After power-on, only the bypass, boundary sample/preload, boundary external-test and factory-unlock opcodes take effect. All other opcodes act as bypass until the factory-unlock opcode has been updated into the instruction register. The unlocked condition survives test-logic reset and the test reset pin, and only power-on reset clears it. The reconfiguration request is only a one-clock pulse. The pin-mode outputs (external test, high-impedance, clamp) are levels for the pin logic.

Top module: `jtag_tap_gated`

## Requirements
- R1: From Test-Logic-Reset, mode-select values 0,1,1,0,0 on five rising edges reach Shift-IR. The serial output enable is high only while the controller is in Shift-IR or Shift-DR. Both serial outputs are low after reset.
- R2: Capture-IR loads 10'b1010101010, so the serial output shows 0,1,0,1,... from the first Shift-IR cycle (least significant bit first).
- R3: After reset the identification instruction is active, even in locked mode. Shift-DR then returns {VERSION[3:0], PART[15:0], 11'h06E, 1'b1}, least significant bit first.
- R4: Five consecutive ones on mode select return the controller to Test-Logic-Reset from any state, and this restores the identification instruction.
- R5: Opcode 10'h3FF selects the 1-bit bypass stage. That stage captures 0 and delays serial data by one clock.
- R6: While locked, opcodes 10'h006, 10'h007, 10'h00B, 10'h00A and 10'h001 behave as bypass. They raise no pin-mode output and no reconfiguration pulse.
- R7: Opcode 10'h281 (factory unlock) selects bypass and opens the gate. After that, 10'h006 selects the identification word, 10'h007 selects the USERCODE word, 10'h00B raises the high-impedance mode and 10'h00A raises the clamp mode, both with the bypass path.
- R8: The unlocked condition survives Test-Logic-Reset and the test reset pin, and is cleared only by power-on reset.
- R9: Opcodes 10'h005 (sample/preload) and 10'h00F (external test) route the serial output from the boundary return input and gate the boundary capture/shift/update strobes, at most one of which is high at a time. 10'h00F also raises the external-test mode.
- R10: When unlocked, updating 10'h001 produces a reconfiguration pulse exactly one clock long, starting at the falling edge in Update-IR.
- R11: Any opcode not listed above behaves as bypass.
- R12: The instruction register and the serial output change on the falling edge of the test clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| porN | input | 1 | Power-on reset, active low; also clears the unlock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| bndSo | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdoEn | output | 1 | Serial output enable |
| bndCapture | output | 1 | Boundary chain capture strobe |
| bndShift | output | 1 | Boundary chain shift strobe |
| bndUpdate | output | 1 | Boundary chain update strobe |
| modeExtest | output | 1 | External-test pin mode |
| modeHighz | output | 1 | High-impedance pin mode |
| modeClamp | output | 1 | Clamp pin mode |
| cfgPulse | output | 1 | One-clock reconfiguration request |

## Verification
The bench loads every opcode twice, once while locked and once after the unlock. Each time it shifts a known 40-bit word through the data path, so the length and the captured value of the selected register show up directly. A gate that leaks would return the identification or user word, or raise a pin mode, while still locked. A gate that ignores the unlock would keep returning the bypass pattern. Further tests show that the unlock outlasts a test-logic reset and the test reset pin but not power-on reset, and that the capture pattern comes out least significant bit first (a reversed register shifts out a leading 1). They also check that a reconfiguration pulse that stays high is caught in the idle state that follows it.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 10;
  localparam int DR_W = 32;
  localparam int MFR_W = 11;
  localparam logic [MFR_W-1:0] MFR_ID = 11'h06E;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'b1010101010;

  localparam logic [IR_W-1:0] OP_BYPASS   = 10'h3FF;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST   = 10'h00F;
  localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
  localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 10'h00B;
  localparam logic [IR_W-1:0] OP_CLAMP    = 10'h00A;
  localparam logic [IR_W-1:0] OP_PULSE    = 10'h001;
  localparam logic [IR_W-1:0] OP_FACTORY  = 10'h281;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [3:0] {
    I_BYPASS, I_SAMPLE, I_EXTEST, I_IDCODE, I_USERCODE,
    I_HIGHZ, I_CLAMP, I_PULSE, I_FACTORY
  } instr_e;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tap_strobe_t;

  // Opcodes behind the gate fall back to bypass while it is closed.
  function automatic instr_e decodeOp(input logic [IR_W-1:0] op, input logic gateOpen);
    instr_e r;
    case (op)
      OP_BYPASS:   r = I_BYPASS;
      OP_SAMPLE:   r = I_SAMPLE;
      OP_EXTEST:   r = I_EXTEST;
      OP_FACTORY:  r = I_FACTORY;
      OP_IDCODE:   r = gateOpen ? I_IDCODE   : I_BYPASS;
      OP_USERCODE: r = gateOpen ? I_USERCODE : I_BYPASS;
      OP_HIGHZ:    r = gateOpen ? I_HIGHZ    : I_BYPASS;
      OP_CLAMP:    r = gateOpen ? I_CLAMP    : I_BYPASS;
      OP_PULSE:    r = gateOpen ? I_PULSE    : I_BYPASS;
      default:     r = I_BYPASS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  logic        tms,
  output tap_state_e  state,
  output tap_strobe_t stb
);

  tap_state_e nextState;

  always_comb begin
    case (state)
      TLR:     nextState = tms ? TLR    : RTI;
      RTI:     nextState = tms ? SEL_DR : RTI;
      SEL_DR:  nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nextState = tms ? EX1_DR : SHF_DR;
      SHF_DR:  nextState = tms ? EX1_DR : SHF_DR;
      EX1_DR:  nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nextState = tms ? UPD_DR : SHF_DR;
      UPD_DR:  nextState = tms ? SEL_DR : RTI;
      SEL_IR:  nextState = tms ? TLR    : CAP_IR;
      CAP_IR:  nextState = tms ? EX1_IR : SHF_IR;
      SHF_IR:  nextState = tms ? EX1_IR : SHF_IR;
      EX1_IR:  nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nextState = tms ? UPD_IR : SHF_IR;
      UPD_IR:  nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= TLR;
    else       state <= nextState;
  end

  always_comb begin
    stb.inReset   = (state == TLR);
    stb.captureIr = (state == CAP_IR);
    stb.shiftIr   = (state == SHF_IR);
    stb.updateIr  = (state == UPD_IR);
    stb.captureDr = (state == CAP_DR);
    stb.shiftDr   = (state == SHF_DR);
    stb.updateDr  = (state == UPD_DR);
  end

endmodule

// File: rtl/jtag_tap_dpath.sv
module jtag_tap_dpath
  import jtag_tap_pkg::*;
#(
  parameter bit                LOCK_EN   = 1'b1,
  parameter logic [3:0]        VERSION   = 4'h3,
  parameter logic [15:0]       PART      = 16'hC3A5,
  parameter logic [DR_W-1:0]   USER_CODE = 32'h1234_5678
) (
  input  logic        tck,
  input  logic        rstN,
  input  logic        porN,
  input  logic        tdi,
  input  logic        bndSo,
  input  tap_strobe_t stb,
  output logic        tdo,
  output logic        tdoEn,
  output instr_e      activeIns,
  output logic        unlocked,
  output logic        cfgPulse
);

  localparam logic [DR_W-1:0] ID_VALUE = {VERSION, PART, MFR_ID, 1'b1};

  logic [IR_W-1:0] irShift;
  logic [DR_W-1:0] drShift;
  logic            bypassBit;
  logic            gateOpen;
  logic            drOut;
  instr_e          nextIns;

  assign gateOpen = !LOCK_EN || unlocked;
  assign nextIns  = decodeOp(irShift, gateOpen);

  // Instruction shift stage: rising edge.
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)              irShift <= '0;
    else if (stb.captureIr) irShift <= IR_CAPTURE;
    else if (stb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Active instruction and unlock: falling edge.
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)             activeIns <= I_IDCODE;
    else if (stb.inReset)  activeIns <= I_IDCODE;
    else if (stb.updateIr) activeIns <= nextIns;
  end

  always_ff @(negedge tck or negedge porN) begin
    if (!porN)                                       unlocked <= 1'b0;
    else if (stb.updateIr && nextIns == I_FACTORY)   unlocked <= 1'b1;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) cfgPulse <= 1'b0;
    else       cfgPulse <= stb.updateIr && (nextIns == I_PULSE);
  end

  // Data registers: rising edge.
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      drShift   <= '0;
      bypassBit <= 1'b0;
    end else if (stb.captureDr) begin
      bypassBit <= 1'b0;
      case (activeIns)
        I_IDCODE:   drShift <= ID_VALUE;
        I_USERCODE: drShift <= USER_CODE;
        default:    drShift <= drShift;
      endcase
    end else if (stb.shiftDr) begin
      bypassBit <= tdi;
      drShift   <= {tdi, drShift[DR_W-1:1]};
    end
  end

  always_comb begin
    case (activeIns)
      I_IDCODE, I_USERCODE: drOut = drShift[0];
      I_SAMPLE, I_EXTEST:   drOut = bndSo;
      default:              drOut = bypassBit;
    endcase
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= stb.shiftIr || stb.shiftDr;
      if (stb.shiftIr)      tdo <= irShift[0];
      else if (stb.shiftDr) tdo <= drOut;
      else                  tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/jtag_tap_gated.sv
module jtag_tap_gated
  import jtag_tap_pkg::*;
#(
  parameter bit          LOCK_EN   = 1'b1,
  parameter logic [3:0]  VERSION   = 4'h3,
  parameter logic [15:0] PART      = 16'hC3A5,
  parameter logic [31:0] USER_CODE = 32'h1234_5678
) (
  input  logic tck,
  input  logic trstN,
  input  logic porN,
  input  logic tms,
  input  logic tdi,
  input  logic bndSo,
  output logic tdo,
  output logic tdoEn,
  output logic bndCapture,
  output logic bndShift,
  output logic bndUpdate,
  output logic modeExtest,
  output logic modeHighz,
  output logic modeClamp,
  output logic cfgPulse
);

  logic        rstN;
  tap_state_e  state;
  tap_strobe_t stb;
  instr_e      activeIns;
  logic        unlocked;
  logic        bndSel;

  assign rstN = trstN && porN;

  jtag_tap_ctrl uCtl (
    .tck   (tck),
    .rstN  (rstN),
    .tms   (tms),
    .state (state),
    .stb   (stb)
  );

  jtag_tap_dpath #(
    .LOCK_EN   (LOCK_EN),
    .VERSION   (VERSION),
    .PART      (PART),
    .USER_CODE (USER_CODE)
  ) uDp (
    .tck       (tck),
    .rstN      (rstN),
    .porN      (porN),
    .tdi       (tdi),
    .bndSo     (bndSo),
    .stb       (stb),
    .tdo       (tdo),
    .tdoEn     (tdoEn),
    .activeIns (activeIns),
    .unlocked  (unlocked),
    .cfgPulse  (cfgPulse)
  );

  assign bndSel     = (activeIns == I_SAMPLE) || (activeIns == I_EXTEST);
  assign bndCapture = bndSel && stb.captureDr;
  assign bndShift   = bndSel && stb.shiftDr;
  assign bndUpdate  = bndSel && stb.updateDr;
  assign modeExtest = (activeIns == I_EXTEST);
  assign modeHighz  = (activeIns == I_HIGHZ);
  assign modeClamp  = (activeIns == I_CLAMP);

endmodule

// File: rtl/jtag_tap_gated_chk.sv
module jtag_tap_gated_chk
  import jtag_tap_pkg::*;
#(
  parameter bit LOCK_EN = 1'b1
) (
  input logic       tck,
  input logic       trstN,
  input logic       porN,
  input logic       tms,
  input logic       tdoEn,
  input logic       cfgPulse,
  input logic       modeHighz,
  input logic       modeClamp,
  input logic       bndCapture,
  input logic       bndShift,
  input logic       bndUpdate,
  input logic       unlocked,
  input tap_state_e state
);

  // R1: output enable follows the shift states
  p_en_shift_r1: assert property (@(posedge tck) disable iff (!(trstN && porN))
    tdoEn == (state == SHF_IR || state == SHF_DR));

  // R4: five ones on mode select land in Test-Logic-Reset
  p_five_ones_r4: assert property (@(posedge tck) disable iff (!(trstN && porN))
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == TLR);

  // R6: nothing gated escapes while locked
  p_locked_quiet_r6: assert property (@(posedge tck) disable iff (!(trstN && porN))
    (LOCK_EN && !unlocked) |-> (!modeHighz && !modeClamp && !cfgPulse));

  // R8: only power-on reset clears the unlock
  p_unlock_sticky_r8: assert property (@(posedge tck) disable iff (!porN)
    $past(unlocked) |-> unlocked);

  // R9: boundary strobes never overlap
  p_bnd_onehot_r9: assert property (@(posedge tck) disable iff (!(trstN && porN))
    $onehot0({bndCapture, bndShift, bndUpdate}));

  // R10: reconfiguration request lasts one clock
  p_pulse_once_r10: assert property (@(posedge tck) disable iff (!(trstN && porN))
    cfgPulse |=> !cfgPulse);

endmodule

bind jtag_tap_gated jtag_tap_gated_chk #(.LOCK_EN(LOCK_EN)) uChk (
  .tck        (tck),
  .trstN      (trstN),
  .porN       (porN),
  .tms        (tms),
  .tdoEn      (tdoEn),
  .cfgPulse   (cfgPulse),
  .modeHighz  (modeHighz),
  .modeClamp  (modeClamp),
  .bndCapture (bndCapture),
  .bndShift   (bndShift),
  .bndUpdate  (bndUpdate),
  .unlocked   (uDp.unlocked),
  .state      (uCtl.state)
);

// File: tb/jtag_tap_gated_test.sv
module jtag_tap_gated_test;

  localparam logic [31:0] ID_EXP   = {4'h3, 16'hC3A5, 11'h06E, 1'b1};
  localparam logic [31:0] USER_EXP = 32'h1234_5678;
  localparam logic [39:0] PAT      = 40'hC3_5A96_E10F;
  localparam int NVEC = 10;
  // {opcode[19:10], lockedType[9:8], unlockedType[7:6], lockedMode[5:3], unlockedMode[2:0]}
  // type: 0 bypass, 1 identification, 2 user word, 3 boundary; mode: {extest, highz, clamp}
  localparam logic [19:0] VEC [NVEC] = '{
    {10'h3FF, 2'd0, 2'd0, 3'b000, 3'b000},
    {10'h005, 2'd3, 2'd3, 3'b000, 3'b000},
    {10'h00F, 2'd3, 2'd3, 3'b100, 3'b100},
    {10'h006, 2'd0, 2'd1, 3'b000, 3'b000},
    {10'h007, 2'd0, 2'd2, 3'b000, 3'b000},
    {10'h00B, 2'd0, 2'd0, 3'b000, 3'b010},
    {10'h00A, 2'd0, 2'd0, 3'b000, 3'b001},
    {10'h001, 2'd0, 2'd0, 3'b000, 3'b000},
    {10'h155, 2'd0, 2'd0, 3'b000, 3'b000},
    {10'h000, 2'd0, 2'd0, 3'b000, 3'b000}
  };

  logic tck = 1'b0;
  logic trstN = 1'b0, porN = 1'b0, tms = 1'b1, tdi = 1'b0, bndSo = 1'b1;
  logic tdo, tdoEn, bndCapture, bndShift, bndUpdate;
  logic modeExtest, modeHighz, modeClamp, cfgPulse;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #2 tck = ~tck;

  jtag_tap_gated uut (
    .tck(tck), .trstN(trstN), .porN(porN), .tms(tms), .tdi(tdi), .bndSo(bndSo),
    .tdo(tdo), .tdoEn(tdoEn), .bndCapture(bndCapture), .bndShift(bndShift),
    .bndUpdate(bndUpdate), .modeExtest(modeExtest), .modeHighz(modeHighz),
    .modeClamp(modeClamp), .cfgPulse(cfgPulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic toReset();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle, load an opcode; returns captured bits and pulse seen at update.
  task automatic loadIr(input logic [9:0] op, output logic [9:0] capt, output logic pulse);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      capt[i] = tdo;
      tick(i == 9, op[i]);
    end
    tick(1'b1, 1'b0);
    pulse = cfgPulse;
    tick(1'b0, 1'b0);
  endtask

  task automatic shiftDr(input logic [39:0] din, output logic [39:0] dout, output logic shSeen);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    shSeen = bndShift;
    for (int i = 0; i < 40; i++) begin
      dout[i] = tdo;
      tick(i == 39, din[i]);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  function automatic logic [39:0] expOut(input logic [1:0] ty, input logic [39:0] din);
    case (ty)
      2'd0: return {din[38:0], 1'b0};
      2'd1: return {din[7:0], ID_EXP};
      2'd2: return {din[7:0], USER_EXP};
      default: return '1;
    endcase
  endfunction

  task automatic runTable(input bit openPhase);
    logic [9:0] capt;
    logic pulse, sh;
    logic [39:0] dout;
    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] op = VEC[v][19:10];
      logic [1:0] ty = openPhase ? VEC[v][7:6] : VEC[v][9:8];
      logic [2:0] md = openPhase ? VEC[v][2:0] : VEC[v][5:3];
      loadIr(op, capt, pulse);
      check("R10 R6 pulse", pulse, openPhase && op == 10'h001);
      check("R6 R7 R9 modes", {modeExtest, modeHighz, modeClamp}, md);
      shiftDr(PAT, dout, sh);
      check("R5 R6 R7 R9 R11 data path", dout, expOut(ty, PAT));
      check("R9 shift strobe", sh, ty == 2'd3);
    end
  endtask

  initial begin
    logic [9:0] capt;
    logic pulse, sh;
    logic [39:0] dout;
    #5 porN = 1'b1; trstN = 1'b1;
    @(negedge tck); #1;
    check("R1 reset tdo", tdo, 1'b0);
    check("R1 reset tdoEn", tdoEn, 1'b0);
    // R1 / R2: walk 0,1,1,0,0 from Test-Logic-Reset
    tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    check("R1 enable off in Capture-IR", tdoEn, 1'b0);
    tick(1'b0, 1'b0);
    check("R1 enable in Shift-IR", tdoEn, 1'b1);
    for (int i = 0; i < 10; i++) begin
      capt[i] = tdo;
      tick(i == 9, 1'b1);
    end
    check("R2 capture pattern", capt, 10'h2AA);
    check("R1 enable off after shift", tdoEn, 1'b0);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    // R4: five ones restore identification instruction (locked still)
    toReset();
    shiftDr(PAT, dout, sh);
    check("R3 R4 id after reset", dout, {PAT[7:0], ID_EXP});
    check("R1 enable idle", tdoEn, 1'b0);
    // R12: tdo changes only after falling edge
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tms = 1'b0; tdi = 1'b0;
    check("R12 tdo holds lsb", tdo, ID_EXP[0]);
    @(posedge tck); #1;
    check("R12 tdo stable after rising edge", tdo, ID_EXP[0]);
    @(negedge tck); #1;
    check("R12 tdo moves at falling edge", tdo, ID_EXP[1]);
    toReset();
    runTable(1'b0);
    // R7: unlock
    loadIr(10'h281, capt, pulse);
    check("R2 capture repeat", capt, 10'h2AA);
    shiftDr(PAT, dout, sh);
    check("R7 unlock opcode is bypass", dout, {PAT[38:0], 1'b0});
    runTable(1'b1);
    // R10: pulse length
    loadIr(10'h001, capt, pulse);
    check("R10 pulse at update", pulse, 1'b1);
    check("R10 pulse gone next clock", cfgPulse, 1'b0);
    // R8: survive TLR and trstN
    toReset();
    loadIr(10'h007, capt, pulse);
    shiftDr(PAT, dout, sh);
    check("R8 unlock survives TLR", dout, {PAT[7:0], USER_EXP});
    trstN = 1'b0; #3 trstN = 1'b1;
    @(negedge tck); #1;
    tick(1'b0, 1'b0);
    loadIr(10'h007, capt, pulse);
    shiftDr(PAT, dout, sh);
    check("R8 unlock survives test reset", dout, {PAT[7:0], USER_EXP});
    porN = 1'b0; #3 porN = 1'b1;
    @(negedge tck); #1;
    tick(1'b0, 1'b0);
    loadIr(10'h007, capt, pulse);
    shiftDr(PAT, dout, sh);
    check("R8 power-on reset relocks", dout, {PAT[38:0], 1'b0});
    loadIr(10'h00B, capt, pulse);
    check("R6 relocked highz ignored", modeHighz, 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule